// File: doc/BRIEF.md
# If-Then Block Predication Unit

This unit lives in an instruction-issue stage and tracks conditional blocks. An if-then instruction carries a 4-bit base condition and a 4-bit pattern mask. When the unit accepts one, it opens a window of up to four following instructions. Each instruction in the window is a Then slot, which uses the base condition, or an Else slot, which uses the inverted condition. For every instruction that issues, the unit decides combinationally, in the same cycle, whether the instruction executes and whether it may write the condition flags.

Each slot is evaluated against the flags as they stand in the cycle the slot issues. A flag change made earlier in the same block therefore changes which later slots run. Carry consumers downstream see the carry written by earlier slots for the same reason. Narrow (16-bit) flag-setting instructions have their flag writes suppressed inside a block, except for the compare class. A breakpoint always executes. A branch anywhere but in the final slot raises a fault. So does an if-then that arrives while a block is still open.

Top module: `it_pred_unit`

## Requirements
- R1: Outside a block, a valid non-if-then instruction has exec_en_o=1 and fault_o=0. Its flag_wr_en_o is 1 when ins_sets_flags_i or ins_is_cmp_i is set, whatever the width.
- R2: An if-then that arrives outside a block drives exec_en_o, flag_wr_en_o and fault_o to 0. If its mask is nonzero, in_block_o is 1 from the next cycle.
- R3: The position of the lowest set mask bit gives the block length: bit 3 gives 1 slot, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. Above that bit, mask bit 3 marks slot 2 Else when 1, bit 2 does the same for slot 3, and bit 1 for slot 4. Slot 1 is always Then. in_block_o drops in the cycle after the last slot issues. A mask of zero opens no block.
- R4: flags_i is {N,Z,C,V} from bit 3 down to bit 0. The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always. An Else slot flips the low bit of the code, except for codes 14 and 15, which stay always.
- R5: A slot is evaluated against flags_i in its own issue cycle, so flags changed mid-block decide whether later slots are enabled.
- R6: Inside a block, an enabled narrow instruction writes flags only if ins_is_cmp_i is set (compare, compare-negative, test). Other narrow flag-setting instructions get flag_wr_en_o=0.
- R7: Inside a block, an enabled wide flag-setting instruction gets flag_wr_en_o=1. A disabled instruction never gets flag_wr_en_o.
- R8: A breakpoint inside a block has exec_en_o=1 whatever its condition evaluates to.
- R9: A branch in any slot but the last asserts fault_o in its issue cycle. A branch in the last slot does not.
- R10: An if-then that arrives while a block is open asserts fault_o with exec_en_o=0. It neither advances nor restarts the block.
- R11: A disabled instruction still uses up its slot.
- R12: Reset clears the block state. While ins_valid_i is 0, all three per-instruction outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | An instruction issues this cycle |
| ins_is_it_i | input | 1 | The issuing instruction is an if-then |
| it_cond_i | input | 4 | Base condition of the if-then |
| it_mask_i | input | MAX_SLOTS | Then/Else pattern and length of the if-then |
| ins_narrow_i | input | 1 | 16-bit encoding |
| ins_sets_flags_i | input | 1 | Flag-setting form of an instruction |
| ins_is_cmp_i | input | 1 | Compare, compare-negative or test |
| ins_is_bkpt_i | input | 1 | Breakpoint |
| ins_is_branch_i | input | 1 | Branch |
| flags_i | input | 4 | Live N,Z,C,V flags |
| exec_en_o | output | 1 | The instruction executes |
| flag_wr_en_o | output | 1 | The instruction may write the flags |
| in_block_o | output | 1 | A block is open |
| fault_o | output | 1 | Misplaced branch or nested if-then |

## Verification
A wrong Then/Else bit in the state shows up as a wrong exec_en_o in the same cycle as the affected slot, provided the flags make the two polarities differ. The sweep varies the flags per slot so that this happens. A wrong block length shows up on in_block_o in the cycle after the intended last slot. It can also show up earlier, as fault_o on a branch that should be allowed. A state register that fails to hold across a nested if-then shows up as a wrong in_block_o within the next one to three issues.

// File: rtl/it_pred_pkg.sv
package it_pred_pkg;
  localparam int COND_W = 4;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_pred_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic              inv_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              pass_o
);
  nzcv_t             f;
  logic [COND_W-1:0] eff;
  logic              base;
  logic              always_cc;

  assign f         = flags_i;
  assign always_cc = &cond_i[COND_W-1:1];

  always_comb begin
    eff = cond_i;
    if (inv_i && !always_cc) eff[0] = ~cond_i[0];
    unique case (eff[COND_W-1:1])
      3'd0:    base = f.z;
      3'd1:    base = f.c;
      3'd2:    base = f.n;
      3'd3:    base = f.v;
      3'd4:    base = f.c & ~f.z;
      3'd5:    base = (f.n == f.v);
      3'd6:    base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
    pass_o = always_cc ? 1'b1 : (base ^ eff[0]);
  end
endmodule

// File: rtl/it_slot_seq.sv
module it_slot_seq
  import it_pred_pkg::*;
#(
  parameter int MAX_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 open_i,
  input  logic [COND_W-1:0]    cond_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  input  logic                 adv_i,
  output logic                 active_o,
  output logic                 last_o,
  output logic [COND_W-1:0]    cond_o,
  output logic                 inv_o
);
  localparam int MSB = MAX_SLOTS - 1;

  logic [COND_W-1:0]    base_q;
  logic [MAX_SLOTS-1:0] pat_q;
  logic                 inv_q;

  assign active_o = |pat_q;
  assign last_o   = pat_q[MSB] & ~|pat_q[MSB-1:0];
  assign cond_o   = base_q;
  assign inv_o    = inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pat_q  <= '0;
      inv_q  <= 1'b0;
    end else if (open_i && |mask_i) begin
      base_q <= cond_i;
      pat_q  <= mask_i;
      inv_q  <= 1'b0;
    end else if (adv_i) begin
      if (last_o) begin
        pat_q <= '0;
        inv_q <= 1'b0;
      end else begin
        inv_q <= pat_q[MSB];
        pat_q <= {pat_q[MSB-1:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/it_issue_ctl.sv
module it_issue_ctl (
  input  logic valid_i,
  input  logic is_it_i,
  input  logic narrow_i,
  input  logic sets_flags_i,
  input  logic is_cmp_i,
  input  logic is_bkpt_i,
  input  logic is_branch_i,
  input  logic active_i,
  input  logic last_i,
  input  logic pass_i,
  output logic exec_en_o,
  output logic flag_wr_en_o,
  output logic fault_o,
  output logic open_o,
  output logic adv_o
);
  logic normal;
  logic enabled;
  logic wr_req;

  assign normal  = valid_i & ~is_it_i;
  assign enabled = ~active_i | pass_i | is_bkpt_i;
  // narrow flag writes are muted in a block; compare class is exempt
  assign wr_req  = is_cmp_i | (sets_flags_i & (~active_i | ~narrow_i));

  assign exec_en_o    = normal & enabled;
  assign flag_wr_en_o = normal & enabled & wr_req;
  assign fault_o      = valid_i & active_i & (is_it_i | (is_branch_i & ~last_i));
  assign open_o       = valid_i & is_it_i & ~active_i;
  assign adv_o        = normal & active_i;
endmodule

// File: rtl/it_pred_unit.sv
module it_pred_unit
  import it_pred_pkg::*;
#(
  parameter int MAX_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_valid_i,
  input  logic                 ins_is_it_i,
  input  logic [3:0]           it_cond_i,
  input  logic [MAX_SLOTS-1:0] it_mask_i,
  input  logic                 ins_narrow_i,
  input  logic                 ins_sets_flags_i,
  input  logic                 ins_is_cmp_i,
  input  logic                 ins_is_bkpt_i,
  input  logic                 ins_is_branch_i,
  input  logic [3:0]           flags_i,
  output logic                 exec_en_o,
  output logic                 flag_wr_en_o,
  output logic                 in_block_o,
  output logic                 fault_o
);
  logic              active;
  logic              last;
  logic [COND_W-1:0] cur_cond;
  logic              cur_inv;
  logic              pass;
  logic              open;
  logic              adv;

  it_slot_seq #(.MAX_SLOTS(MAX_SLOTS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (open),
    .cond_i   (it_cond_i),
    .mask_i   (it_mask_i),
    .adv_i    (adv),
    .active_o (active),
    .last_o   (last),
    .cond_o   (cur_cond),
    .inv_o    (cur_inv)
  );

  it_cond_eval u_eval (
    .cond_i  (cur_cond),
    .inv_i   (cur_inv),
    .flags_i (flags_i),
    .pass_o  (pass)
  );

  it_issue_ctl u_ctl (
    .valid_i      (ins_valid_i),
    .is_it_i      (ins_is_it_i),
    .narrow_i     (ins_narrow_i),
    .sets_flags_i (ins_sets_flags_i),
    .is_cmp_i     (ins_is_cmp_i),
    .is_bkpt_i    (ins_is_bkpt_i),
    .is_branch_i  (ins_is_branch_i),
    .active_i     (active),
    .last_i       (last),
    .pass_i       (pass),
    .exec_en_o    (exec_en_o),
    .flag_wr_en_o (flag_wr_en_o),
    .fault_o      (fault_o),
    .open_o       (open),
    .adv_o        (adv)
  );

  assign in_block_o = active;
endmodule

// File: rtl/it_pred_chk.sv
module it_pred_chk #(
  parameter int MAX_SLOTS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ins_valid_i,
  input logic ins_is_it_i,
  input logic ins_narrow_i,
  input logic ins_is_cmp_i,
  input logic ins_is_bkpt_i,
  input logic exec_en_o,
  input logic flag_wr_en_o,
  input logic in_block_o,
  input logic fault_o
);
  localparam int CW = $clog2(MAX_SLOTS + 1);

  logic [CW-1:0] slot_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_cnt <= '0;
    else if (!in_block_o) slot_cnt <= '0;
    else if (ins_valid_i && !ins_is_it_i) slot_cnt <= slot_cnt + 1'b1;
  end

  p_idle_exec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && !ins_is_it_i && !in_block_o |-> exec_en_o && !fault_o);

  p_block_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_block_o && ins_valid_i && !ins_is_it_i |-> slot_cnt < CW'(MAX_SLOTS));

  p_narrow_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && in_block_o && !ins_is_it_i && ins_narrow_i && !ins_is_cmp_i
    |-> !flag_wr_en_o);

  p_no_write_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_en_o |-> exec_en_o);

  p_bkpt_runs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && in_block_o && !ins_is_it_i && ins_is_bkpt_i |-> exec_en_o);

  p_nested_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && ins_is_it_i && in_block_o |-> fault_o && !exec_en_o);

  p_nested_keeps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && ins_is_it_i && in_block_o |=> in_block_o);

  p_quiet_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_valid_i |-> !exec_en_o && !flag_wr_en_o && !fault_o);
endmodule

bind it_pred_unit it_pred_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ins_valid_i   (ins_valid_i),
  .ins_is_it_i   (ins_is_it_i),
  .ins_narrow_i  (ins_narrow_i),
  .ins_is_cmp_i  (ins_is_cmp_i),
  .ins_is_bkpt_i (ins_is_bkpt_i),
  .exec_en_o     (exec_en_o),
  .flag_wr_en_o  (flag_wr_en_o),
  .in_block_o    (in_block_o),
  .fault_o       (fault_o)
);

// File: tb/sim_it_pred_unit.sv
`timescale 1ns/1ps
module sim_it_pred_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ins_valid_i = 1'b0;
  logic       ins_is_it_i = 1'b0;
  logic [3:0] it_cond_i = '0;
  logic [3:0] it_mask_i = '0;
  logic       ins_narrow_i = 1'b0;
  logic       ins_sets_flags_i = 1'b0;
  logic       ins_is_cmp_i = 1'b0;
  logic       ins_is_bkpt_i = 1'b0;
  logic       ins_is_branch_i = 1'b0;
  logic [3:0] flags_i = '0;
  logic       exec_en_o, flag_wr_en_o, in_block_o, fault_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  it_pred_unit u0 (.*);

  function automatic bit ref_pass(logic [3:0] c, logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, sample combinational outputs 2 ns later
  task automatic drive(bit v, bit it, logic [3:0] c, logic [3:0] m, bit nar,
                       bit sf, bit cmp, bit bk, bit br, logic [3:0] fl);
    @(negedge clk_i);
    ins_valid_i = v; ins_is_it_i = it; it_cond_i = c; it_mask_i = m;
    ins_narrow_i = nar; ins_sets_flags_i = sf; ins_is_cmp_i = cmp;
    ins_is_bkpt_i = bk; ins_is_branch_i = br; flags_i = fl;
    #2;
  endtask

  task automatic open_blk(logic [3:0] c, logic [3:0] m);
    drive(1, 1, c, m, 0, 0, 0, 0, 0, 4'h0);
  endtask

  task automatic plain(logic [3:0] fl);
    drive(1, 0, 4'h0, 4'h0, 0, 0, 0, 0, 0, fl);
  endtask

  task automatic idle();
    drive(0, 0, 4'h0, 4'h0, 0, 0, 0, 0, 0, 4'h0);
  endtask

  initial begin
    #1;
    chk("R12 reset in_block", in_block_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    chk("R12 idle exec", exec_en_o, 1'b0);
    chk("R12 idle fault", fault_o, 1'b0);

    // R1: outside a block
    for (int k = 0; k < 8; k++) begin
      drive(1, 0, 4'h0, 4'h0, k[0], k[1], k[2], 0, 0, 4'(k));
      chk("R1 exec", exec_en_o, 1'b1);
      chk("R1 flag_wr", flag_wr_en_o, k[1] | k[2]);
      chk("R1 fault", fault_o, 1'b0);
    end

    // R2/R3/R4/R6/R7/R11: sweep every condition and mask
    for (int c = 0; c < 15; c++) begin
      for (int m = 1; m < 16; m++) begin
        logic [3:0] mv;
        int t;
        int nsl;
        mv = 4'(m);
        t = 0;
        while (!mv[t]) t++;
        nsl = 4 - t;
        open_blk(4'(c), mv);
        chk("R2 it exec", exec_en_o, 1'b0);
        chk("R2 it flag_wr", flag_wr_en_o, 1'b0);
        chk("R2 it fault", fault_o, 1'b0);
        for (int k = 0; k < nsl; k++) begin
          bit inv;
          logic [3:0] ec;
          logic [3:0] fl;
          int cls;
          bit pass;
          inv = (k == 0) ? 1'b0 : mv[4-k];
          ec = 4'(c);
          if (inv && ec[3:1] != 3'b111) ec[0] = ~ec[0];
          fl = 4'(c * 5 + m * 3 + k * 7 + 1);
          cls = (c + m + k) % 4;
          pass = ref_pass(ec, fl);
          drive(1, 0, 4'h0, 4'h0, cls != 1, cls != 3, cls == 2, 0, 0, fl);
          chk("R3 in_block", in_block_o, 1'b1);
          chk("R4 R11 exec", exec_en_o, pass);
          chk("R6 R7 flag_wr", flag_wr_en_o, pass && (cls == 1 || cls == 2));
        end
        idle();
        chk("R3 block closed", in_block_o, 1'b0);
      end
    end

    // R3: zero mask opens nothing
    open_blk(4'd0, 4'h0);
    idle();
    chk("R3 zero mask", in_block_o, 1'b0);

    // R5: later slot disabled after Z cleared mid-block
    open_blk(4'd0, 4'b0100);
    drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 4'b0100);
    chk("R5 slot1 exec", exec_en_o, 1'b1);
    chk("R5 slot1 cmp writes", flag_wr_en_o, 1'b1);
    plain(4'b0000);
    chk("R5 slot2 disabled", exec_en_o, 1'b0);
    // R5: later slot enabled after Z cleared
    open_blk(4'd1, 4'b0100);
    plain(4'b0100);
    chk("R5 NE slot1", exec_en_o, 1'b0);
    plain(4'b0000);
    chk("R5 NE slot2", exec_en_o, 1'b1);

    // R8: breakpoint with failing condition
    open_blk(4'd0, 4'b1000);
    drive(1, 0, 0, 0, 1, 0, 0, 1, 0, 4'b0000);
    chk("R8 bkpt exec", exec_en_o, 1'b1);

    // R9: branch placement
    open_blk(4'd14, 4'b0100);
    drive(1, 0, 0, 0, 1, 0, 0, 0, 1, 4'h0);
    chk("R9 early branch fault", fault_o, 1'b1);
    drive(1, 0, 0, 0, 1, 0, 0, 0, 1, 4'h0);
    chk("R9 last branch ok", fault_o, 1'b0);

    // R10: nested if-then
    open_blk(4'd14, 4'b0010);
    plain(4'h0);
    open_blk(4'd0, 4'b1000);
    chk("R10 nested fault", fault_o, 1'b1);
    chk("R10 nested exec", exec_en_o, 1'b0);
    plain(4'h0);
    chk("R10 slot2 in block", in_block_o, 1'b1);
    plain(4'h0);
    chk("R10 slot3 in block", in_block_o, 1'b1);
    idle();
    chk("R10 closed after 3", in_block_o, 1'b0);

    // R12: reset mid-block
    open_blk(4'd14, 4'b0001);
    plain(4'h0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    chk("R12 reset clears", in_block_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    plain(4'h0);
    chk("R12 post reset idle", exec_en_o, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule